// File: doc/BRIEF.md
# Branch Trace Message Encoder

This block sits beside a processor core's retirement stage and turns the stream of retired instructions into compact program-flow trace messages. For each retired instruction it is told the instruction length, a class (plain, conditional branch, indirect branch, trap), a taken flag and the target address. Instructions whose successor can be worked out from the program image raise no message; they only advance an instruction counter kept in 16-bit units. Only flow changes that cannot be inferred produce a message. A debugger rebuilds the executed path from these messages and the program image.

Two modes exist. In the branch mode every taken conditional branch yields a direct-branch message. In the history mode conditional outcomes are packed as bits into a history register, and that register is emitted with the next indirect branch or trap. Starting and stopping trace emit a synchronisation and a correlation message. When the counter or the history register would run out of room, a resource-full message empties it. Messages leave one per cycle through a valid/ready handshake. Retirement is held off by `ret_ready` whenever the block cannot accept another message.

Top module: `trace_msg_encoder`

## Requirements
- R1: After reset `msg_valid` is 0, and `ret_ready` stays 0 until tracing has started.
- R2: When `trace_en` rises while tracing is off, a sync message is emitted with kind 0. It carries `msg_addr` = `start_pc`, `msg_code` = `sync_reason`, and `msg_icnt` = 0 and `msg_hist` = 0. The counter restarts at 0 and the history at 1.
- R3: When `trace_en` falls while tracing is on, a correlation message is emitted with kind 4. It carries the current count and `msg_code` = `stop_reason`, plus the history in history mode (0 in branch mode). While `trace_en` is 0, `ret_ready` is 0.
- R4: A retired 16-bit instruction (`ret_wide`=0) adds 1 to the count, and a 32-bit one (`ret_wide`=1) adds 2. The count in a message includes the instruction that raised it. Counting restarts from 0 after any message that carries the count.
- R5: A plain instruction (`ret_class`=0) never produces a message, and neither does a not-taken conditional branch (`ret_class`=1) in branch mode (`mode_hist`=0).
- R6: In branch mode a taken conditional branch emits a direct-branch message: kind 1, with the count, `msg_hist` 0 and `msg_addr` 0.
- R7: An indirect branch (`ret_class`=2) emits kind 2 with the count and `msg_addr` = `ret_target`. In history mode with a non-empty history (value other than 1), it instead emits kind 3, which also carries the history; the history then returns to 1.
- R8: In history mode a conditional branch emits nothing and shifts its taken flag into the history at bit 0. A leading 1 marks how many bits are valid.
- R9: A trap (`ret_class`=3) emits kind 6 in both modes, with the count and `msg_addr` = `ret_target`. In history mode it also carries the history and resets it to 1; in branch mode `msg_hist` is 0.
- R10: If adding an instruction would take the count past 2^ICNT_W-1, a resource-full message (kind 5, `msg_code` 0) with the old count is emitted. The count restarts at that instruction's increment. This message comes before any message the same instruction raises.
- R11: In history mode, when a shift would move the marker into bit HIST_W-1, a resource-full message (kind 5, `msg_code` 1) carrying the shifted history is emitted, and the history returns to 1.
- R12: While `msg_valid` is 1 and `msg_ready` is 0, the message fields hold steady and `ret_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| trace_en | input | 1 | Trace enable; its edges start and stop tracing |
| mode_hist | input | 1 | 0 = branch mode, 1 = history mode; change only while tracing is off |
| start_pc | input | ADDR_W | Full address placed in the sync message |
| sync_reason | input | CODE_W | Start reason placed in the sync message |
| stop_reason | input | CODE_W | Stop reason placed in the correlation message |
| ret_valid | input | 1 | A retired instruction is presented |
| ret_ready | output | 1 | The presented instruction is accepted this cycle |
| ret_wide | input | 1 | 1 = 32-bit instruction, 0 = 16-bit |
| ret_class | input | 2 | 0 plain, 1 conditional, 2 indirect, 3 trap |
| ret_taken | input | 1 | Conditional branch outcome |
| ret_target | input | ADDR_W | Target address of an indirect branch or trap |
| msg_valid | output | 1 | A message is offered |
| msg_ready | input | 1 | The consumer takes the offered message |
| msg_kind | output | 3 | Message kind code |
| msg_icnt | output | ICNT_W | Instruction count field |
| msg_hist | output | HIST_W | History field |
| msg_addr | output | ADDR_W | Address field |
| msg_code | output | CODE_W | Reason or resource-full selector |

## Verification
On every cycle the assertions check the following. The offered message holds still and retirement is refused while the consumer stalls. Nothing retires while trace is disabled. The history marker stays inside the register. A history resource-full message has its top bit set, and sync messages have empty count and history fields. The bench's reference model is needed for everything that depends on the sequence of instructions: the count in 16-bit units, the order of a resource-full message ahead of the branch message from the same instruction, the history bit order, and the choice between kinds 2 and 3 on an empty history. Directed runs fill the counter and the history to their limits and stall the consumer.

// File: rtl/trace_enc_pkg.sv
package trace_enc_pkg;

   localparam int KIND_W = 3;

   // message kinds
   localparam logic [KIND_W-1:0] K_SYNC     = 3'd0;
   localparam logic [KIND_W-1:0] K_DIRECT   = 3'd1;
   localparam logic [KIND_W-1:0] K_INDIRECT = 3'd2;
   localparam logic [KIND_W-1:0] K_IND_HIST = 3'd3;
   localparam logic [KIND_W-1:0] K_CORREL   = 3'd4;
   localparam logic [KIND_W-1:0] K_RESFULL  = 3'd5;
   localparam logic [KIND_W-1:0] K_TRAP     = 3'd6;

   // retired instruction classes
   localparam logic [1:0] C_PLAIN    = 2'd0;
   localparam logic [1:0] C_COND     = 2'd1;
   localparam logic [1:0] C_INDIRECT = 2'd2;
   localparam logic [1:0] C_TRAP     = 2'd3;

   // resource-full selectors (low bit of the code field)
   localparam logic FULL_ICNT = 1'b0;
   localparam logic FULL_HIST = 1'b1;

endpackage

// File: rtl/trace_icnt_ctr.sv
module trace_icnt_ctr #(
   parameter int ICNT_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step,
   input  logic              wide,
   input  logic              clr_after,
   input  logic              restart,
   output logic [ICNT_W-1:0] cnt_q,
   output logic [ICNT_W-1:0] cnt_incl,
   output logic              ovf
);

   localparam int SUM_W = ICNT_W + 1;

   generate
      if (ICNT_W < 2) begin : g_bad_width
         initial $error("trace_icnt_ctr: ICNT_W must be at least 2");
      end
   endgenerate

   logic [SUM_W-1:0] inc;
   logic [SUM_W-1:0] sum;

   always_comb begin
      inc      = wide ? SUM_W'(2) : SUM_W'(1);
      sum      = {1'b0, cnt_q} + inc;
      ovf      = sum[ICNT_W];
      cnt_incl = ovf ? inc[ICNT_W-1:0] : sum[ICNT_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (restart) begin
         cnt_q <= '0;
      end else if (step) begin
         cnt_q <= clr_after ? '0 : cnt_incl;
      end
   end

endmodule

// File: rtl/trace_hist_reg.sv
module trace_hist_reg #(
   parameter int HIST_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              shift_en,
   input  logic              bit_in,
   input  logic              clr,
   output logic [HIST_W-1:0] hist_q,
   output logic [HIST_W-1:0] shifted,
   output logic              full,
   output logic              empty
);

   localparam logic [HIST_W-1:0] MARK_ONLY = HIST_W'(1);

   generate
      if (HIST_W < 2) begin : g_bad_width
         initial $error("trace_hist_reg: HIST_W must be at least 2");
      end
   endgenerate

   always_comb begin
      shifted = {hist_q[HIST_W-2:0], bit_in};
      full    = shifted[HIST_W-1];
      empty   = (hist_q == MARK_ONLY);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hist_q <= MARK_ONLY;
      end else if (clr) begin
         hist_q <= MARK_ONLY;
      end else if (shift_en) begin
         hist_q <= full ? MARK_ONLY : shifted;
      end
   end

endmodule

// File: rtl/trace_msg_build.sv
module trace_msg_build
   import trace_enc_pkg::*;
#(
   parameter int ICNT_W = 8,
   parameter int HIST_W = 32,
   parameter int ADDR_W = 32,
   parameter int CODE_W = 4,
   localparam int MSG_W = KIND_W + ICNT_W + HIST_W + ADDR_W + CODE_W
) (
   input  logic              start_ev,
   input  logic              stop_ev,
   input  logic              ret_fire,
   input  logic              mode_hist,
   input  logic [1:0]        ret_class,
   input  logic              ret_taken,
   input  logic [ADDR_W-1:0] ret_target,
   input  logic [ADDR_W-1:0] start_pc,
   input  logic [CODE_W-1:0] sync_reason,
   input  logic [CODE_W-1:0] stop_reason,
   input  logic [ICNT_W-1:0] icnt_q,
   input  logic [ICNT_W-1:0] icnt_incl,
   input  logic              icnt_ovf,
   input  logic [HIST_W-1:0] hist_q,
   input  logic [HIST_W-1:0] hist_shifted,
   input  logic              hist_full,
   input  logic              hist_empty,
   output logic              m0_v,
   output logic [MSG_W-1:0]  m0_d,
   output logic              m1_v,
   output logic [MSG_W-1:0]  m1_d,
   output logic              icnt_restart,
   output logic              icnt_clr_after,
   output logic              hist_shift,
   output logic              hist_clr
);

   function automatic logic [MSG_W-1:0] pack(
      input logic [KIND_W-1:0] k,
      input logic [ICNT_W-1:0] c,
      input logic [HIST_W-1:0] h,
      input logic [ADDR_W-1:0] a,
      input logic [CODE_W-1:0] r
   );
      return {k, c, h, a, r};
   endfunction

   logic             ins_v;
   logic [MSG_W-1:0] ins_d;
   logic             rfh_v;
   logic [MSG_W-1:0] rfh_d;
   logic [MSG_W-1:0] rfi_d;

   always_comb begin
      rfi_d = pack(K_RESFULL, icnt_q, '0, '0, CODE_W'(FULL_ICNT));
      rfh_d = pack(K_RESFULL, '0, hist_shifted, '0, CODE_W'(FULL_HIST));
   end

   always_comb begin
      m0_v           = 1'b0;
      m0_d           = '0;
      m1_v           = 1'b0;
      m1_d           = '0;
      icnt_restart   = 1'b0;
      icnt_clr_after = 1'b0;
      hist_shift     = 1'b0;
      hist_clr       = 1'b0;
      ins_v          = 1'b0;
      ins_d          = '0;
      rfh_v          = 1'b0;
      if (start_ev) begin
         m0_v         = 1'b1;
         m0_d         = pack(K_SYNC, '0, '0, start_pc, sync_reason);
         icnt_restart = 1'b1;
         hist_clr     = 1'b1;
      end else if (stop_ev) begin
         m0_v         = 1'b1;
         m0_d         = pack(K_CORREL, icnt_q, mode_hist ? hist_q : '0, '0, stop_reason);
         icnt_restart = 1'b1;
         hist_clr     = 1'b1;
      end else if (ret_fire) begin
         case (ret_class)
            C_COND: begin
               if (mode_hist) begin
                  hist_shift = 1'b1;
               end else if (ret_taken) begin
                  ins_v = 1'b1;
                  ins_d = pack(K_DIRECT, icnt_incl, '0, '0, '0);
               end
            end
            C_INDIRECT: begin
               ins_v = 1'b1;
               if (mode_hist && !hist_empty) begin
                  ins_d    = pack(K_IND_HIST, icnt_incl, hist_q, ret_target, '0);
                  hist_clr = 1'b1;
               end else begin
                  ins_d = pack(K_INDIRECT, icnt_incl, '0, ret_target, '0);
               end
            end
            C_TRAP: begin
               ins_v    = 1'b1;
               ins_d    = pack(K_TRAP, icnt_incl, mode_hist ? hist_q : '0, ret_target, '0);
               hist_clr = mode_hist;
            end
            default: begin
            end
         endcase
         icnt_clr_after = ins_v;
         rfh_v          = hist_shift && hist_full;
         // counter overflow always leaves first
         if (icnt_ovf) begin
            m0_v = 1'b1;
            m0_d = rfi_d;
            m1_v = ins_v || rfh_v;
            m1_d = rfh_v ? rfh_d : ins_d;
         end else begin
            m0_v = ins_v || rfh_v;
            m0_d = rfh_v ? rfh_d : ins_d;
         end
      end
   end

endmodule

// File: rtl/trace_msg_slots.sv
module trace_msg_slots #(
   parameter int MSG_W = 80
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in0_v,
   input  logic [MSG_W-1:0] in0_d,
   input  logic             in1_v,
   input  logic [MSG_W-1:0] in1_d,
   input  logic             out_ready,
   output logic             out_valid,
   output logic [MSG_W-1:0] out_data,
   output logic             can_take
);

   logic             s0_v;
   logic             s1_v;
   logic [MSG_W-1:0] s0_d;
   logic [MSG_W-1:0] s1_d;
   logic             pop;

   always_comb begin
      pop       = s0_v && out_ready;
      can_take  = !s1_v && (!s0_v || out_ready);
      out_valid = s0_v;
      out_data  = s0_d;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s0_v <= 1'b0;
         s1_v <= 1'b0;
         s0_d <= '0;
         s1_d <= '0;
      end else if (in0_v) begin
         s0_v <= 1'b1;
         s0_d <= in0_d;
         s1_v <= in1_v;
         s1_d <= in1_d;
      end else if (pop) begin
         if (s1_v) begin
            s0_d <= s1_d;
            s1_v <= 1'b0;
         end else begin
            s0_v <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/trace_msg_encoder.sv
module trace_msg_encoder
   import trace_enc_pkg::*;
#(
   parameter int ICNT_W = 8,
   parameter int HIST_W = 32,
   parameter int ADDR_W = 32,
   parameter int CODE_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              trace_en,
   input  logic              mode_hist,
   input  logic [ADDR_W-1:0] start_pc,
   input  logic [CODE_W-1:0] sync_reason,
   input  logic [CODE_W-1:0] stop_reason,
   input  logic              ret_valid,
   output logic              ret_ready,
   input  logic              ret_wide,
   input  logic [1:0]        ret_class,
   input  logic              ret_taken,
   input  logic [ADDR_W-1:0] ret_target,
   output logic              msg_valid,
   input  logic              msg_ready,
   output logic [KIND_W-1:0] msg_kind,
   output logic [ICNT_W-1:0] msg_icnt,
   output logic [HIST_W-1:0] msg_hist,
   output logic [ADDR_W-1:0] msg_addr,
   output logic [CODE_W-1:0] msg_code
);

   localparam int MSG_W = KIND_W + ICNT_W + HIST_W + ADDR_W + CODE_W;

   generate
      if (CODE_W < 1 || ADDR_W < 1) begin : g_bad_width
         initial $error("trace_msg_encoder: CODE_W and ADDR_W must be positive");
      end
   endgenerate

   logic              tracing;
   logic              can_take;
   logic              start_ev;
   logic              stop_ev;
   logic              ret_fire;
   logic [ICNT_W-1:0] icnt_q;
   logic [ICNT_W-1:0] icnt_incl;
   logic              icnt_ovf;
   logic              icnt_restart;
   logic              icnt_clr_after;
   logic [HIST_W-1:0] hist_q;
   logic [HIST_W-1:0] hist_shifted;
   logic              hist_full;
   logic              hist_empty;
   logic              hist_shift;
   logic              hist_clr;
   logic              m0_v;
   logic              m1_v;
   logic [MSG_W-1:0]  m0_d;
   logic [MSG_W-1:0]  m1_d;
   logic [MSG_W-1:0]  out_data;

   always_comb begin
      start_ev  = can_take && !tracing && trace_en;
      stop_ev   = can_take && tracing && !trace_en;
      ret_ready = can_take && tracing && trace_en;
      ret_fire  = ret_ready && ret_valid;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tracing <= 1'b0;
      end else if (start_ev) begin
         tracing <= 1'b1;
      end else if (stop_ev) begin
         tracing <= 1'b0;
      end
   end

   trace_icnt_ctr #(.ICNT_W(ICNT_W)) u_icnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .step      (ret_fire),
      .wide      (ret_wide),
      .clr_after (icnt_clr_after),
      .restart   (icnt_restart),
      .cnt_q     (icnt_q),
      .cnt_incl  (icnt_incl),
      .ovf       (icnt_ovf)
   );

   trace_hist_reg #(.HIST_W(HIST_W)) u_hist (
      .clk      (clk),
      .rst_n    (rst_n),
      .shift_en (hist_shift),
      .bit_in   (ret_taken),
      .clr      (hist_clr),
      .hist_q   (hist_q),
      .shifted  (hist_shifted),
      .full     (hist_full),
      .empty    (hist_empty)
   );

   trace_msg_build #(
      .ICNT_W (ICNT_W),
      .HIST_W (HIST_W),
      .ADDR_W (ADDR_W),
      .CODE_W (CODE_W)
   ) u_build (
      .start_ev       (start_ev),
      .stop_ev        (stop_ev),
      .ret_fire       (ret_fire),
      .mode_hist      (mode_hist),
      .ret_class      (ret_class),
      .ret_taken      (ret_taken),
      .ret_target     (ret_target),
      .start_pc       (start_pc),
      .sync_reason    (sync_reason),
      .stop_reason    (stop_reason),
      .icnt_q         (icnt_q),
      .icnt_incl      (icnt_incl),
      .icnt_ovf       (icnt_ovf),
      .hist_q         (hist_q),
      .hist_shifted   (hist_shifted),
      .hist_full      (hist_full),
      .hist_empty     (hist_empty),
      .m0_v           (m0_v),
      .m0_d           (m0_d),
      .m1_v           (m1_v),
      .m1_d           (m1_d),
      .icnt_restart   (icnt_restart),
      .icnt_clr_after (icnt_clr_after),
      .hist_shift     (hist_shift),
      .hist_clr       (hist_clr)
   );

   trace_msg_slots #(.MSG_W(MSG_W)) u_slots (
      .clk       (clk),
      .rst_n     (rst_n),
      .in0_v     (m0_v),
      .in0_d     (m0_d),
      .in1_v     (m1_v),
      .in1_d     (m1_d),
      .out_ready (msg_ready),
      .out_valid (msg_valid),
      .out_data  (out_data),
      .can_take  (can_take)
   );

   assign {msg_kind, msg_icnt, msg_hist, msg_addr, msg_code} = out_data;

endmodule

// File: rtl/trace_enc_checker.sv
module trace_enc_checker #(
   parameter int ICNT_W = 8,
   parameter int HIST_W = 32,
   parameter int ADDR_W = 32,
   parameter int CODE_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              trace_en,
   input logic              ret_ready,
   input logic              msg_valid,
   input logic              msg_ready,
   input logic [2:0]        msg_kind,
   input logic [ICNT_W-1:0] msg_icnt,
   input logic [HIST_W-1:0] msg_hist,
   input logic [ADDR_W-1:0] msg_addr,
   input logic [CODE_W-1:0] msg_code,
   input logic [HIST_W-1:0] hist_q
);

   p_stall_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_valid && !msg_ready) |-> !ret_ready);

   p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_kind) && $stable(msg_icnt)
                                     && $stable(msg_hist) && $stable(msg_addr) && $stable(msg_code)));

   p_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !trace_en |-> !ret_ready);

   p_marker_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (hist_q != '0) && !hist_q[HIST_W-1]);

   p_hist_full_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_valid && msg_kind == 3'd5 && msg_code == CODE_W'(1)) |-> msg_hist[HIST_W-1]);

   p_sync_clean_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_valid && msg_kind == 3'd0) |-> (msg_icnt == '0 && msg_hist == '0));

endmodule

bind trace_msg_encoder trace_enc_checker #(
   .ICNT_W (ICNT_W),
   .HIST_W (HIST_W),
   .ADDR_W (ADDR_W),
   .CODE_W (CODE_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .trace_en  (trace_en),
   .ret_ready (ret_ready),
   .msg_valid (msg_valid),
   .msg_ready (msg_ready),
   .msg_kind  (msg_kind),
   .msg_icnt  (msg_icnt),
   .msg_hist  (msg_hist),
   .msg_addr  (msg_addr),
   .msg_code  (msg_code),
   .hist_q    (hist_q)
);

// File: tb/trace_msg_encoder_tb_top.sv
module trace_msg_encoder_tb_top;

   localparam int CLK_PERIOD = 10;

   typedef struct packed {
      logic [2:0]  k;
      logic [7:0]  c;
      logic [31:0] h;
      logic [31:0] a;
      logic [3:0]  r;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        trace_en = 1'b0;
   logic        mode_hist = 1'b0;
   logic [31:0] start_pc = '0;
   logic [3:0]  sync_reason = '0;
   logic [3:0]  stop_reason = '0;
   logic        ret_valid = 1'b0;
   logic        ret_ready;
   logic        ret_wide = 1'b0;
   logic [1:0]  ret_class = '0;
   logic        ret_taken = 1'b0;
   logic [31:0] ret_target = '0;
   logic        msg_valid;
   logic        msg_ready = 1'b0;
   logic [2:0]  msg_kind;
   logic [7:0]  msg_icnt;
   logic [31:0] msg_hist;
   logic [31:0] msg_addr;
   logic [3:0]  msg_code;

   always #(CLK_PERIOD/2) clk = ~clk;

   trace_msg_encoder dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .trace_en    (trace_en),
      .mode_hist   (mode_hist),
      .start_pc    (start_pc),
      .sync_reason (sync_reason),
      .stop_reason (stop_reason),
      .ret_valid   (ret_valid),
      .ret_ready   (ret_ready),
      .ret_wide    (ret_wide),
      .ret_class   (ret_class),
      .ret_taken   (ret_taken),
      .ret_target  (ret_target),
      .msg_valid   (msg_valid),
      .msg_ready   (msg_ready),
      .msg_kind    (msg_kind),
      .msg_icnt    (msg_icnt),
      .msg_hist    (msg_hist),
      .msg_addr    (msg_addr),
      .msg_code    (msg_code)
   );

   int          n_checks = 0;
   int          n_fail = 0;
   bit          done = 0;
   bit          fired;
   string       ctx = "random";
   exp_t        expq[$];
   int          m_icnt = 0;
   logic [31:0] m_hist = 32'd1;
   bit          m_on = 0;
   bit          m_mode = 0;

   function automatic exp_t mk(logic [2:0] k, int c, logic [31:0] h, logic [31:0] a, logic [3:0] r);
      exp_t e;
      e.k = k; e.c = 8'(c); e.h = h; e.a = a; e.r = r;
      return e;
   endfunction

   function automatic string tag_of(exp_t e);
      case (e.k)
         3'd0: return "R2";
         3'd1: return "R6";
         3'd2, 3'd3: return "R7";
         3'd4: return "R3";
         3'd5: return (e.r == 4'd0) ? "R10" : "R11";
         default: return "R9";
      endcase
   endfunction

   function automatic void check(bit ok, string tag, string what, logic [79:0] act, logic [79:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s (%s) %s: actual=%h expected=%h", tag, ctx, what, act, exp);
      end
   endfunction

   // reference model of one accepted retirement
   function automatic void model_retire(logic [1:0] cls, bit wide, bit tk, logic [31:0] tgt);
      int          inc = wide ? 2 : 1;
      logic [31:0] nh;
      if (m_icnt + inc > 255) begin
         expq.push_back(mk(3'd5, m_icnt, '0, '0, 4'd0));
         m_icnt = inc;
      end else begin
         m_icnt = m_icnt + inc;
      end
      case (cls)
         2'd1: begin
            if (m_mode) begin
               nh = {m_hist[30:0], tk};
               if (nh[31]) begin
                  expq.push_back(mk(3'd5, 0, nh, '0, 4'd1));
                  m_hist = 32'd1;
               end else begin
                  m_hist = nh;
               end
            end else if (tk) begin
               expq.push_back(mk(3'd1, m_icnt, '0, '0, 4'd0));
               m_icnt = 0;
            end
         end
         2'd2: begin
            if (m_mode && m_hist != 32'd1) begin
               expq.push_back(mk(3'd3, m_icnt, m_hist, tgt, 4'd0));
               m_hist = 32'd1;
            end else begin
               expq.push_back(mk(3'd2, m_icnt, '0, tgt, 4'd0));
            end
            m_icnt = 0;
         end
         2'd3: begin
            expq.push_back(mk(3'd6, m_icnt, m_mode ? m_hist : '0, tgt, 4'd0));
            if (m_mode) m_hist = 32'd1;
            m_icnt = 0;
         end
         default: begin
         end
      endcase
   endfunction

   function automatic void compare_pop();
      exp_t a;
      exp_t e;
      a = {msg_kind, msg_icnt, msg_hist, msg_addr, msg_code};
      if (expq.size() == 0) begin
         check(1'b0, "R5", "message with none expected", a, '0);
      end else begin
         e = expq.pop_front();
         check(a == e, tag_of(e), "message content", a, e);
      end
   endfunction

   task automatic observe();
      fired = 0;
      if (msg_valid && msg_ready) compare_pop();
      if (ret_valid && ret_ready) begin
         fired = 1;
         model_retire(ret_class, ret_wide, ret_taken, ret_target);
      end
   endtask

   task automatic step(bit v, logic [1:0] cls, bit w, bit tk, logic [31:0] tgt, bit rdy);
      @(negedge clk);
      ret_valid  = v;
      ret_class  = cls;
      ret_wide   = w;
      ret_taken  = tk;
      ret_target = tgt;
      msg_ready  = rdy;
      #1;
      observe();
   endtask

   task automatic retire(logic [1:0] cls, bit w, bit tk, logic [31:0] tgt, bit rdy);
      for (int i = 0; i < 50; i++) begin
         step(1'b1, cls, w, tk, tgt, rdy);
         if (fired) break;
      end
   endtask

   task automatic drain(int n);
      for (int i = 0; i < n; i++) step(1'b0, 2'd0, 1'b0, 1'b0, '0, 1'b1);
   endtask

   task automatic set_en(bit val, logic [31:0] pc, logic [3:0] why);
      @(negedge clk);
      if (val && !m_on) begin
         start_pc    = pc;
         sync_reason = why;
         expq.push_back(mk(3'd0, 0, '0, pc, why));
         m_icnt = 0;
         m_hist = 32'd1;
      end else if (!val && m_on) begin
         stop_reason = why;
         expq.push_back(mk(3'd4, m_icnt, m_mode ? m_hist : '0, '0, why));
         m_icnt = 0;
         m_hist = 32'd1;
      end
      m_on     = val;
      trace_en = val;
      drain(6);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      logic [2:0]  k0;
      logic [7:0]  c0;
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1: idle after reset
      check(msg_valid == 1'b0, "R1", "msg_valid after reset", 80'(msg_valid), 80'(0));
      check(ret_ready == 1'b0, "R1", "ret_ready before start", 80'(ret_ready), 80'(0));

      // branch mode basics
      ctx = "R2 sync";
      m_mode = 0; mode_hist = 1'b0;
      set_en(1'b1, 32'h0000_1000, 4'd3);
      ctx = "R5 silent";
      retire(2'd0, 1'b0, 1'b0, '0, 1'b1);
      retire(2'd0, 1'b0, 1'b0, '0, 1'b1);
      retire(2'd0, 1'b1, 1'b0, '0, 1'b1);
      retire(2'd1, 1'b0, 1'b0, '0, 1'b1);
      drain(2);
      check(msg_valid == 1'b0, "R5", "no message for plain or not-taken", 80'(msg_valid), 80'(0));
      ctx = "R4 count 1+1+2+1+1";
      retire(2'd2, 1'b0, 1'b0, 32'h0000_2000, 1'b1);
      drain(2);
      ctx = "R6 direct";
      retire(2'd0, 1'b1, 1'b0, '0, 1'b1);
      retire(2'd1, 1'b0, 1'b1, 32'h0000_3000, 1'b1);
      drain(2);
      ctx = "R10 count overflow";
      for (int i = 0; i < 127; i++) retire(2'd0, 1'b1, 1'b0, '0, 1'b1);
      retire(2'd2, 1'b1, 1'b0, 32'h0000_4000, 1'b1);
      drain(3);
      ctx = "R9 trap branch mode";
      retire(2'd3, 1'b0, 1'b0, 32'h0000_0100, 1'b1);
      drain(2);

      // R12: consumer stall
      ctx = "R12 stall";
      retire(2'd2, 1'b0, 1'b0, 32'h0000_5000, 1'b0);
      step(1'b1, 2'd0, 1'b0, 1'b0, '0, 1'b0);
      k0 = msg_kind; c0 = msg_icnt;
      for (int i = 0; i < 3; i++) begin
         step(1'b1, 2'd0, 1'b0, 1'b0, '0, 1'b0);
         check(ret_ready == 1'b0, "R12", "ret_ready during stall", 80'(ret_ready), 80'(0));
         check(msg_valid && msg_kind == k0 && msg_icnt == c0, "R12", "message held",
               80'({msg_valid, msg_kind, msg_icnt}), 80'({1'b1, k0, c0}));
      end
      drain(3);

      // stop and refusal while disabled
      ctx = "R3 stop";
      retire(2'd0, 1'b1, 1'b0, '0, 1'b1);
      set_en(1'b0, '0, 4'd5);
      step(1'b1, 2'd2, 1'b0, 1'b0, 32'h0000_6000, 1'b1);
      check(ret_ready == 1'b0, "R3", "ret_ready while disabled", 80'(ret_ready), 80'(0));
      drain(2);

      // history mode
      m_mode = 1; mode_hist = 1'b1;
      ctx = "R2 sync history";
      set_en(1'b1, 32'h0000_8000, 4'd1);
      ctx = "R8 history bits";
      retire(2'd1, 1'b0, 1'b1, '0, 1'b1);
      retire(2'd1, 1'b0, 1'b0, '0, 1'b1);
      retire(2'd1, 1'b1, 1'b1, '0, 1'b1);
      drain(2);
      check(msg_valid == 1'b0, "R8", "no message for history-mode conditional", 80'(msg_valid), 80'(0));
      retire(2'd2, 1'b0, 1'b0, 32'h0000_9000, 1'b1);
      ctx = "R7 empty history";
      retire(2'd2, 1'b0, 1'b0, 32'h0000_A000, 1'b1);
      ctx = "R9 trap history";
      retire(2'd1, 1'b0, 1'b0, '0, 1'b1);
      retire(2'd3, 1'b1, 1'b0, 32'h0000_0200, 1'b1);
      drain(2);
      ctx = "R11 history full";
      for (int i = 0; i < 31; i++) retire(2'd1, 1'b0, 1'b1, '0, 1'b1);
      retire(2'd3, 1'b0, 1'b0, 32'h0000_0300, 1'b1);
      drain(3);
      ctx = "R3 stop history";
      retire(2'd1, 1'b0, 1'b1, '0, 1'b1);
      set_en(1'b0, '0, 4'd7);

      // constrained random rounds
      ctx = "random";
      for (int r = 0; r < 6; r++) begin
         m_mode = r[0]; mode_hist = r[0];
         set_en(1'b1, $urandom(), 4'($urandom_range(0, 15)));
         for (int i = 0; i < 600; i++) begin
            int          pick = $urandom_range(0, 99);
            logic [1:0]  cls = (pick < 50) ? 2'd0 : (pick < 78) ? 2'd1 : (pick < 92) ? 2'd2 : 2'd3;
            step($urandom_range(0, 3) != 0, cls, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                 $urandom(), $urandom_range(0, 3) != 0);
         end
         set_en(1'b0, '0, 4'($urandom_range(0, 15)));
      end

      drain(4);
      check(expq.size() == 0, "R3", "all expected messages seen", 80'(expq.size()), 80'(0));
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule